// File: doc/BRIEF.md
# Repeated Byte String Copy Engine

This block carries out a counted forward byte copy, the hardware form of a single repeat-prefixed move-byte instruction. Software presents a byte count, a source pointer and a destination pointer on the load inputs and pulses `start`. The engine then walks the run one byte at a time over a byte-wide memory port. For each byte it reads from the source address, writes that byte to the destination address, and then steps its architectural registers. The register values can be read on the output ports at any time, and they are checked once the copy has finished.

The control is a four-state machine with these states:
- `ST_IDLE`: waiting for `start`.
- `ST_READ`: a read request at the source pointer is outstanding.
- `ST_WRITE`: a write request of the fetched byte at the destination pointer is outstanding.
- `ST_DONE`: the one-cycle completion pulse.

The machine takes these transitions:
- **IDLE→READ**: `start` arrives with a nonzero count. The registers are loaded.
- **IDLE→DONE**: `start` arrives with a zero count. The registers are loaded and no memory access is made.
- **READ→WRITE**: the read is accepted. The byte is captured.
- **WRITE→READ**: the write is accepted and more than one byte remained. The pointers step up and the count steps down.
- **WRITE→DONE**: the write of the last byte is accepted.
- **DONE→IDLE**: always taken, on the next cycle.

In every other case the state holds. A request stays asserted, with a fixed address and direction, until `mem_ready` accepts it.

Top module: `bytecopy_engine`

## Requirements
- R1: When `start` is high in `ST_IDLE`, the registers take `cnt_in`, `src_in` and `dst_in` at that clock edge, and `busy` is high from the next cycle.
- R2: Each iteration first issues a read (`mem_we`=0) at `src_q`. The write of the captured byte (`mem_we`=1) at `dst_q` is issued only after that read has been accepted.
- R3: On every accepted write, `src_q` and `dst_q` each increase by one and `cnt_q` decreases by one.
- R4: Exactly `cnt_in` reads and `cnt_in` writes take place, at ascending addresses. At completion `cnt_q` is 0 and both pointers have advanced by the original count. Pointer arithmetic is 32-bit and carries across byte boundaries.
- R5: A zero count makes no memory request, leaves both pointers at their loaded values, and still produces the `done` pulse.
- R6: `done` is high for exactly one cycle. `busy` stays high from the cycle after start through the `done` cycle and is low afterwards.
- R7: A `start` pulse while `busy` is high, including during the `done` cycle, changes no register and starts no new copy.
- R8: While `mem_req` is high and `mem_ready` is low, the request, its address and its direction hold unchanged.
- R9: When the regions overlap, the copy has strictly byte-by-byte forward semantics. A destination just above the source therefore replicates the first source byte.
- R10: After reset the engine is idle: `busy`, `done` and `mem_req` are low and all three registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; acted on only when idle |
| cnt_in | input | 32 | Byte count to load |
| src_in | input | 32 | Source pointer to load |
| dst_in | input | 32 | Destination pointer to load |
| cnt_q | output | 32 | Count register |
| src_q | output | 32 | Source pointer register |
| dst_q | output | 32 | Destination pointer register |
| busy | output | 1 | Copy in progress (through the done cycle) |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid when a read is accepted |
| mem_ready | input | 1 | Accepts the current request |

## Verification
The completion pulse and a fresh start request can land in the same cycle. `done` is still high, so the engine is still busy and the new request must be dropped. The bench provokes this by raising `start` with a different count and pointers in the very cycle it sees `done`. It then judges that one cycle later `busy` is low, the final register values are intact, and no further reads or writes were made. Stalled memory acceptance is also mixed into the copies, and the bench compares its whole memory image against an independent forward-copy model.

// File: rtl/bc_pkg.sv
package bc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } bc_state_t;
endpackage

// File: rtl/bc_ctrl.sv
module bc_ctrl
    import bc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      load_zero,
    input  logic      cnt_last,
    input  logic      mem_ready,
    output bc_state_t state,
    output logic      load,
    output logic      rd_take,
    output logic      wr_take,
    output logic      mem_req,
    output logic      mem_we,
    output logic      busy,
    output logic      done
);
    bc_state_t state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = load_zero ? ST_DONE : ST_READ;
            ST_READ:  if (mem_ready) state_nx = ST_WRITE;
            ST_WRITE: if (mem_ready) state_nx = cnt_last ? ST_DONE : ST_READ;
            ST_DONE:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        load    = 1'b0;
        rd_take = 1'b0;
        wr_take = 1'b0;
        mem_req = 1'b0;
        mem_we  = 1'b0;
        busy    = 1'b1;
        done    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                load = start;
            end
            ST_READ: begin
                mem_req = 1'b1;
                rd_take = mem_ready;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                wr_take = mem_ready;
            end
            ST_DONE: done = 1'b1;
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/bc_regs.sv
module bc_regs #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              rd_take,
    input  logic              wr_take,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic [DATA_W-1:0] byte_q,
    output logic              cnt_last,
    output logic              load_zero
);
    localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);
    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            byte_q <= '0;
        end else begin
            if (load) begin
                cnt_q <= cnt_in;
                src_q <= src_in;
                dst_q <= dst_in;
            end else if (wr_take) begin
                cnt_q <= cnt_q - CNT_ONE;
                src_q <= src_q + ADDR_ONE;
                dst_q <= dst_q + ADDR_ONE;
            end
            if (rd_take) byte_q <= mem_rdata;
        end
    end

    assign cnt_last  = (cnt_q == CNT_ONE);
    assign load_zero = (cnt_in == '0);
endmodule

// File: rtl/bytecopy_engine.sv
module bytecopy_engine
    import bc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  cnt_in,
    input  logic [ADDR_W-1:0] src_in,
    input  logic [ADDR_W-1:0] dst_in,
    output logic [CNT_W-1:0]  cnt_q,
    output logic [ADDR_W-1:0] src_q,
    output logic [ADDR_W-1:0] dst_q,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    bc_state_t state;
    logic load, rd_take, wr_take, cnt_last, load_zero;
    logic [DATA_W-1:0] byte_q;

    bc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load_zero(load_zero), .cnt_last(cnt_last), .mem_ready(mem_ready),
        .state(state), .load(load), .rd_take(rd_take), .wr_take(wr_take),
        .mem_req(mem_req), .mem_we(mem_we), .busy(busy), .done(done)
    );

    bc_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(load), .rd_take(rd_take),
        .wr_take(wr_take), .cnt_in(cnt_in), .src_in(src_in), .dst_in(dst_in),
        .mem_rdata(mem_rdata), .cnt_q(cnt_q), .src_q(src_q), .dst_q(dst_q),
        .byte_q(byte_q), .cnt_last(cnt_last), .load_zero(load_zero)
    );

    assign mem_addr  = mem_we ? dst_q : src_q;
    assign mem_wdata = byte_q;
endmodule

// File: rtl/bc_checker.sv
module bc_checker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [CNT_W-1:0]  cnt_in,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [ADDR_W-1:0] src_q,
    input logic [ADDR_W-1:0] dst_q,
    input logic              busy,
    input logic              done,
    input logic              mem_req,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_ready
);
    p_busy_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    p_write_follows_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ready) |=> (mem_req && mem_we));

    p_req_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ready) |=>
        (src_q == $past(src_q) + 1 && dst_q == $past(dst_q) + 1 && cnt_q == $past(cnt_q) - 1));

    p_done_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cnt_q == '0));

    p_zero_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cnt_in == '0) |=> (done && !mem_req));

    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(mem_req && mem_we && mem_ready)) |=>
        ($stable(cnt_q) && $stable(src_q) && $stable(dst_q)));

    p_hold_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));
endmodule

bind bytecopy_engine bc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(cnt_in), .cnt_q(cnt_q),
    .src_q(src_q), .dst_q(dst_q), .busy(busy), .done(done), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_ready(mem_ready)
);

// File: tb/sim_bytecopy_engine.sv
`timescale 1ns/1ps
module sim_bytecopy_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] cnt_in = '0, src_in = '0, dst_in = '0;
    logic [31:0] cnt_q, src_q, dst_q, mem_addr;
    logic busy, done, mem_req, mem_we, mem_ready;
    logic [7:0] mem_wdata, mem_rdata;

    always #2 clk = ~clk;

    bytecopy_engine u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_in(cnt_in),
        .src_in(src_in), .dst_in(dst_in), .cnt_q(cnt_q), .src_q(src_q),
        .dst_q(dst_q), .busy(busy), .done(done), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // memory model
    logic [7:0] mem  [256];
    logic [7:0] refm [256];
    logic [7:0] lfsr = 8'hA5;
    logic stall_en = 1'b0;
    int rd_cnt = 0, wr_cnt = 0;
    bit pending = 0, ord_bad = 0;

    assign mem_rdata = mem[mem_addr[7:0]];
    assign mem_ready = mem_req & ~(stall_en & lfsr[0]);

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if (rst_n && mem_req && mem_ready) begin
            if (!mem_we) begin
                rd_cnt++;
                if (pending) ord_bad = 1;
                pending = 1;
            end else begin
                wr_cnt++;
                if (!pending) ord_bad = 1;
                pending = 0;
                mem[mem_addr[7:0]] = mem_wdata;
            end
        end
    end

    int checks = 0, errs = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 256; i++) begin
            mem[i]  = 8'((i * 7 + 3) ^ 8'h5A);
            refm[i] = 8'((i * 7 + 3) ^ 8'h5A);
        end
    endtask

    task automatic model_copy(input logic [31:0] c, input logic [31:0] s, input logic [31:0] d);
        for (int i = 0; i < int'(c); i++) begin
            logic [31:0] sa, da;
            sa = s + 32'(i);
            da = d + 32'(i);
            refm[da[7:0]] = refm[sa[7:0]];
        end
    endtask

    task automatic pulse_start(input logic [31:0] c, input logic [31:0] s, input logic [31:0] d);
        @(negedge clk);
        cnt_in = c; src_in = s; dst_in = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_copy(input logic [31:0] c, input logic [31:0] s,
                            input logic [31:0] d, input bit se, input string tag);
        int mism = 0;
        stall_en = se;
        rd_cnt = 0; wr_cnt = 0; ord_bad = 0;
        model_copy(c, s, d);
        pulse_start(c, s, d);
        chk(busy == 1'b1, {"R1 busy after start ", tag}, 32'(busy), 1);
        wait_done();
        chk(done && cnt_q == 0, {"R4 final count ", tag}, cnt_q, 0);
        chk(src_q == s + c, {"R3 src final ", tag}, src_q, s + c);
        chk(dst_q == d + c, {"R3 dst final ", tag}, dst_q, d + c);
        chk(rd_cnt == int'(c) && wr_cnt == int'(c), {"R4 access count ", tag}, 32'(rd_cnt + wr_cnt), 2 * c);
        chk(!ord_bad, {"R2 read before write ", tag}, 32'(ord_bad), 0);
        @(negedge clk);
        for (int i = 0; i < 256; i++) if (mem[i] != refm[i]) mism++;
        chk(mism == 0, {"R9 memory image ", tag}, 32'(mism), 0);
        chk(!busy && !done, {"R6 idle after done ", tag}, {busy, done}, 0);
        stall_en = 0;
    endtask

    localparam int NV = 6;
    localparam logic [31:0] V_CNT [NV] = '{32'd3, 32'd5, 32'd1, 32'd4, 32'd4, 32'd3};
    localparam logic [31:0] V_SRC [NV] = '{32'h10, 32'h20, 32'h1000_0030, 32'h50, 32'h71, 32'hFE};
    localparam logic [31:0] V_DST [NV] = '{32'h40, 32'h60, 32'h80, 32'h51, 32'h70, 32'h20};
    localparam bit          V_STL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};

    initial begin
        init_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!busy && !done && !mem_req, "R10 control idle", {busy, done, mem_req}, 0);
        chk(cnt_q == 0 && src_q == 0 && dst_q == 0, "R10 registers zero", cnt_q | src_q | dst_q, 0);

        // table: R4 plain, R8 stalls, carry, R9 overlap up and down
        for (int v = 0; v < NV; v++)
            run_copy(V_CNT[v], V_SRC[v], V_DST[v], V_STL[v], $sformatf("vec%0d", v));

        // R5 zero count
        rd_cnt = 0; wr_cnt = 0;
        pulse_start(32'd0, 32'h33, 32'h44);
        chk(done == 1'b1, "R5 done on zero count", 32'(done), 1);
        chk(src_q == 32'h33 && dst_q == 32'h44, "R5 pointers unchanged", src_q ^ 32'h33 | dst_q ^ 32'h44, 0);
        @(negedge clk);
        chk(rd_cnt == 0 && wr_cnt == 0 && !busy, "R5 no memory access", 32'(rd_cnt + wr_cnt), 0);

        // R7 start while mid-copy, then start in the done cycle
        rd_cnt = 0; wr_cnt = 0;
        model_copy(32'd6, 32'h90, 32'hA0);
        pulse_start(32'd6, 32'h90, 32'hA0);
        @(negedge clk);
        cnt_in = 32'd2; src_in = 32'h0; dst_in = 32'h8; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        chk(src_q == 32'h96 && dst_q == 32'hA6, "R7 mid-copy start ignored", src_q, 32'h96);
        cnt_in = 32'd9; src_in = 32'h11; dst_in = 32'h22; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(!busy && cnt_q == 0 && src_q == 32'h96 && dst_q == 32'hA6, "R7 done-cycle start ignored", src_q, 32'h96);
        repeat (4) @(negedge clk);
        chk(rd_cnt == 6 && wr_cnt == 6 && !busy, "R7 no extra accesses", 32'(rd_cnt + wr_cnt), 12);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errs++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd100000, 32'd0);
            $display("  Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule